// File: doc/BRIEF.md
# Flash Query Geometry Reader

This block is a host-side sequencer that learns the layout of a parallel NOR flash by reading its standard query table. A single-cycle `start` pulse makes it issue two command writes at the device base address: first the status-clear code, then the query-entry code. It then walks a fixed list of table offsets. Each offset becomes a byte address on a 16-bit bus, computed as the base plus the offset shifted left by one. Every read keeps only the low byte of the returned word.

The first three bytes read must spell the query signature. If they do, the block decodes the following from log2 exponents and from split little-endian byte pairs:

- the device size,
- the write buffer depth,
- the maximum block erase time,
- the block count and block size of two erase regions.

The sequence always ends with a return-to-array write. After that write, `done` rises and the result registers are loaded. An invalid signature cuts the table walk short. The return-to-array write and `done` still follow, and every geometry output reads zero.

Top module: `flash_geom_reader`

## Requirements
- R1: After reset, a `start` pulse is accepted only while `busy` is low. The cycle after acceptance has `busy` high and `done` low. A `start` seen while `busy` is high adds no bus cycles and does not restart the walk.
- R2: The first two bus cycles after acceptance are writes to address `BASE`. The first writes data 0x0050 and the second writes data 0x0098.
- R3: The table reads then follow in this order: offsets 0x10, 0x11, 0x12, 0x25, 0x27, 0x2A, 0x2D, 0x2E, 0x2F, 0x30, 0x31, 0x32, 0x33, 0x34. Each read drives `bus_rd` for one cycle at address `BASE + 2*offset`. The read data is sampled on `bus_rdata` in the following cycle.
- R4: Only bits [7:0] of each read word are used; bits [15:8] have no effect on any output.
- R5: The signature bytes at 0x10, 0x11 and 0x12 must equal 0x51, 0x52 and 0x59 (ASCII Q, R, Y).
  - On any mismatch, no read follows the 0x12 read.
  - `sig_ok` is 0 and all seven geometry outputs are zero.
  - When all three match, `sig_ok` is 1.
- R6: `dev_bytes` equals 2^n, where n is the byte at 0x27. The output is 0 when n ≥ `VAL_W`.
- R7: `wbuf_words` equals 2^n / 2 (in 16-bit words), where n is the byte at 0x2A. It is 0 when n is 0 or n ≥ `VAL_W`.
- R8: `erase_time` equals 2^n, where n is the byte at 0x25. It is 0 when n ≥ `VAL_W`.
- R9: `r1_blocks` equals byte(0x2D) + 256·byte(0x2E) + 1, in 17 bits, so 0xFFFF pairs give 65536. `r2_blocks` uses 0x31 and 0x32 in the same way.
- R10: `r1_bytes` equals (byte(0x2F) + 256·byte(0x30))·256, in 24 bits. `r2_bytes` uses 0x33 and 0x34 in the same way.
- R11: The last bus cycle of each walk is a write of 0x00FF to `BASE`. In the next cycle:
  - `done` is high and `busy` is low;
  - `done` and all results hold until the next accepted `start`, which clears `done`;
  - a write and a read are never driven together.
- R12: While and just after reset, `busy`, `done`, `sig_ok`, `bus_we`, `bus_rd` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a geometry read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Results valid, held until next start |
| sig_ok | output | 1 | Query signature matched |
| dev_bytes | output | VAL_W | Device size in bytes |
| wbuf_words | output | VAL_W | Write buffer depth in 16-bit words |
| erase_time | output | VAL_W | Maximum block erase time, in device units |
| r1_blocks | output | 17 | Region 1 block count |
| r1_bytes | output | 24 | Region 1 block size in bytes |
| r2_blocks | output | 17 | Region 2 block count |
| r2_bytes | output | 24 | Region 2 block size in bytes |
| bus_addr | output | ADDR_W | Byte address to the flash |
| bus_we | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench builds the block with `ADDR_W` = 12, `BASE` = 0x200 and `VAL_W` = 32.

- A nonzero base makes every address check see both the base term and the doubled offset.
- A 32-bit result width allows an exponent of 31 to land on the top bit, while exponents of 32 and above fall into the zero case.
- The flash model places 0xA5 in the upper byte of every word, so any leak of those bits shows up in the decoded values.
- Tables with all-ones byte pairs reach the 17-bit count and 24-bit size limits.

// File: rtl/flash_geom_pkg.sv
package flash_geom_pkg;

  localparam int NUM_RD  = 14;
  localparam int IDX_W   = $clog2(NUM_RD);
  localparam int SIG_LEN = 3;
  localparam int CNT_W   = 17;
  localparam int BSZ_W   = 24;

  localparam logic [15:0] CMD_CLR = 16'h0050;
  localparam logic [15:0] CMD_QRY = 16'h0098;
  localparam logic [15:0] CMD_ARR = 16'h00FF;

  // slot numbers inside the capture array
  localparam int IX_ERASE = 3;
  localparam int IX_SIZE  = 4;
  localparam int IX_WBUF  = 5;
  localparam int IX_R1CNT = 6;
  localparam int IX_R1SZ  = 8;
  localparam int IX_R2CNT = 10;
  localparam int IX_R2SZ  = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WCLR, ST_WQRY, ST_RISS, ST_RCAP, ST_WARR
  } seq_state_e;

  function automatic logic [7:0] tbl_off(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    tbl_off = 8'h10;
      4'd1:    tbl_off = 8'h11;
      4'd2:    tbl_off = 8'h12;
      4'd3:    tbl_off = 8'h25;
      4'd4:    tbl_off = 8'h27;
      4'd5:    tbl_off = 8'h2A;
      4'd6:    tbl_off = 8'h2D;
      4'd7:    tbl_off = 8'h2E;
      4'd8:    tbl_off = 8'h2F;
      4'd9:    tbl_off = 8'h30;
      4'd10:   tbl_off = 8'h31;
      4'd11:   tbl_off = 8'h32;
      4'd12:   tbl_off = 8'h33;
      4'd13:   tbl_off = 8'h34;
      default: tbl_off = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] sig_char(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    sig_char = 8'h51;
      4'd1:    sig_char = 8'h52;
      default: sig_char = 8'h59;
    endcase
  endfunction

endpackage

// File: rtl/flash_geom_seq.sv
module flash_geom_seq
  import flash_geom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sig_fail,
  output logic              accept,
  output logic              cap_en,
  output logic              finish,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic              bus_rd,
  output logic [15:0]       bus_wdata
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_RD - 1);
  localparam logic [IDX_W-1:0] IDX_SIG  = IDX_W'(SIG_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    idx_en    = 1'b0;
    accept    = 1'b0;
    cap_en    = 1'b0;
    finish    = 1'b0;
    bus_we    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    bus_addr  = BASE;
    case (state_q)
      ST_IDLE: if (start) begin
        accept  = 1'b1;
        state_d = ST_WCLR;
      end
      ST_WCLR: begin
        bus_we    = 1'b1;
        bus_wdata = CMD_CLR;
        state_d   = ST_WQRY;
      end
      ST_WQRY: begin
        bus_we    = 1'b1;
        bus_wdata = CMD_QRY;
        idx_d     = '0;
        idx_en    = 1'b1;
        state_d   = ST_RISS;
      end
      ST_RISS: begin
        bus_rd   = 1'b1;
        bus_addr = BASE + ADDR_W'({tbl_off(idx_q), 1'b0});
        state_d  = ST_RCAP;
      end
      ST_RCAP: begin
        cap_en = 1'b1;
        if ((idx_q == IDX_SIG && sig_fail) || idx_q == IDX_LAST) begin
          state_d = ST_WARR;
        end else begin
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
          state_d = ST_RISS;
        end
      end
      ST_WARR: begin
        bus_we    = 1'b1;
        bus_wdata = CMD_ARR;
        finish    = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign idx  = idx_q;

endmodule

// File: rtl/flash_geom_capture.sv
module flash_geom_capture
  import flash_geom_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         cap_en,
  input  logic [IDX_W-1:0]             idx,
  input  logic [7:0]                   rd_byte,
  output logic                         sig_fail,
  output logic                         sig_bad,
  output logic [NUM_RD-1:0][7:0]       tbl
);

  logic sig_bad_q;
  logic miss_now;

  assign miss_now = cap_en && (int'(idx) < SIG_LEN) && (rd_byte != sig_char(idx));
  assign sig_fail = sig_bad_q | miss_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sig_bad_q <= 1'b0;
    else if (clr)            sig_bad_q <= 1'b0;
    else if (miss_now)       sig_bad_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q <= '0;
      else if (cap_en && idx == IDX_W'(g))          slot_q <= rd_byte;
    end
    assign tbl[g] = slot_q;
  end

  assign sig_bad = sig_bad_q;

endmodule

// File: rtl/flash_geom_decode.sv
module flash_geom_decode
  import flash_geom_pkg::*;
#(
  parameter int VAL_W = 32
) (
  input  logic [NUM_RD-1:0][7:0] tbl,
  input  logic                   sig_bad,
  output logic [VAL_W-1:0]       dev_bytes,
  output logic [VAL_W-1:0]       wbuf_words,
  output logic [VAL_W-1:0]       erase_time,
  output logic [CNT_W-1:0]       r1_blocks,
  output logic [BSZ_W-1:0]       r1_bytes,
  output logic [CNT_W-1:0]       r2_blocks,
  output logic [BSZ_W-1:0]       r2_bytes
);

  function automatic logic [VAL_W-1:0] pow2(input logic [7:0] n);
    if (int'(n) >= VAL_W) pow2 = '0;
    else                  pow2 = VAL_W'(1) << n;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_of(input logic [7:0] lo, input logic [7:0] hi);
    cnt_of = {1'b0, hi, lo} + CNT_W'(1);
  endfunction

  always_comb begin
    if (sig_bad) begin
      dev_bytes  = '0;
      wbuf_words = '0;
      erase_time = '0;
      r1_blocks  = '0;
      r1_bytes   = '0;
      r2_blocks  = '0;
      r2_bytes   = '0;
    end else begin
      dev_bytes  = pow2(tbl[IX_SIZE]);
      wbuf_words = pow2(tbl[IX_WBUF]) >> 1;
      erase_time = pow2(tbl[IX_ERASE]);
      r1_blocks  = cnt_of(tbl[IX_R1CNT], tbl[IX_R1CNT+1]);
      r2_blocks  = cnt_of(tbl[IX_R2CNT], tbl[IX_R2CNT+1]);
      r1_bytes   = {tbl[IX_R1SZ+1], tbl[IX_R1SZ], 8'h00};
      r2_bytes   = {tbl[IX_R2SZ+1], tbl[IX_R2SZ], 8'h00};
    end
  end

endmodule

// File: rtl/flash_geom_reader.sv
module flash_geom_reader
  import flash_geom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int VAL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              sig_ok,
  output logic [VAL_W-1:0]  dev_bytes,
  output logic [VAL_W-1:0]  wbuf_words,
  output logic [VAL_W-1:0]  erase_time,
  output logic [16:0]       r1_blocks,
  output logic [23:0]       r1_bytes,
  output logic [16:0]       r2_blocks,
  output logic [23:0]       r2_bytes,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic              bus_rd,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata
);

  logic                   accept, cap_en, finish, sig_fail, sig_bad;
  logic [IDX_W-1:0]       idx;
  logic [NUM_RD-1:0][7:0] tbl;
  logic [VAL_W-1:0]       dev_d, wbuf_d, ers_d;
  logic [CNT_W-1:0]       r1c_d, r2c_d;
  logic [BSZ_W-1:0]       r1s_d, r2s_d;
  logic                   unused_rd_hi;

  assign unused_rd_hi = ^bus_rdata[15:8];

  flash_geom_seq #(.ADDR_W(ADDR_W), .BASE(BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sig_fail(sig_fail),
    .accept(accept), .cap_en(cap_en), .finish(finish), .busy(busy),
    .idx(idx), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata)
  );

  flash_geom_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .cap_en(cap_en), .idx(idx),
    .rd_byte(bus_rdata[7:0]), .sig_fail(sig_fail), .sig_bad(sig_bad), .tbl(tbl)
  );

  flash_geom_decode #(.VAL_W(VAL_W)) u_dec (
    .tbl(tbl), .sig_bad(sig_bad),
    .dev_bytes(dev_d), .wbuf_words(wbuf_d), .erase_time(ers_d),
    .r1_blocks(r1c_d), .r1_bytes(r1s_d), .r2_blocks(r2c_d), .r2_bytes(r2s_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      sig_ok     <= 1'b0;
      dev_bytes  <= '0;
      wbuf_words <= '0;
      erase_time <= '0;
      r1_blocks  <= '0;
      r1_bytes   <= '0;
      r2_blocks  <= '0;
      r2_bytes   <= '0;
    end else begin
      if (accept)      done <= 1'b0;
      else if (finish) done <= 1'b1;
      if (finish) begin
        sig_ok     <= ~sig_bad;
        dev_bytes  <= dev_d;
        wbuf_words <= wbuf_d;
        erase_time <= ers_d;
        r1_blocks  <= r1c_d;
        r1_bytes   <= r1s_d;
        r2_blocks  <= r2c_d;
        r2_bytes   <= r2s_d;
      end
    end
  end

endmodule

// File: rtl/flash_geom_reader_chk.sv
module flash_geom_reader_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int VAL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              sig_ok,
  input logic [VAL_W-1:0]  dev_bytes,
  input logic [VAL_W-1:0]  wbuf_words,
  input logic [VAL_W-1:0]  erase_time,
  input logic [16:0]       r1_blocks,
  input logic [23:0]       r1_bytes,
  input logic [16:0]       r2_blocks,
  input logic [23:0]       r2_bytes,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_rd,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata
);

  logic [ADDR_W-1:0] rel_addr;
  assign rel_addr = bus_addr - BASE;

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done));

  a_r2_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_we && bus_addr == BASE && bus_wdata == 16'h0050));

  a_r3_even_offset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (rel_addr[0] == 1'b0));

  a_r5_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sig_ok) |-> (dev_bytes == '0 && wbuf_words == '0 && erase_time == '0 &&
                           r1_blocks == '0 && r1_bytes == '0 &&
                           r2_blocks == '0 && r2_bytes == '0));

  a_r11_array_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_we && bus_addr == BASE && bus_wdata == 16'h00FF));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_rd));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !bus_rd));

  logic unused_chk;
  assign unused_chk = ^bus_rdata;

endmodule

bind flash_geom_reader flash_geom_reader_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .VAL_W(VAL_W)
) u_chk (.*);

// File: tb/flash_geom_reader_tb.sv
module flash_geom_reader_tb;

  localparam int ADDR_W = 12;
  localparam logic [11:0] BASE = 12'h200;
  localparam int VAL_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, sig_ok;
  logic [31:0] dev_bytes, wbuf_words, erase_time;
  logic [16:0] r1_blocks, r2_blocks;
  logic [23:0] r1_bytes, r2_bytes;
  logic [11:0] bus_addr;
  logic        bus_we, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = 16'h0;

  always #10 clk = ~clk;

  flash_geom_reader #(.ADDR_W(ADDR_W), .BASE(BASE), .VAL_W(VAL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sig_ok(sig_ok), .dev_bytes(dev_bytes), .wbuf_words(wbuf_words),
    .erase_time(erase_time), .r1_blocks(r1_blocks), .r1_bytes(r1_bytes),
    .r2_blocks(r2_blocks), .r2_bytes(r2_bytes), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // flash model: table indexed by word offset, upper byte is junk
  logic [7:0] tbl [0:63];
  always @(posedge clk) begin
    if (bus_rd) bus_rdata <= {8'hA5, tbl[6'((bus_addr - BASE) >> 1)]};
  end

  // scoreboard of expected bus cycles: {we, addr, data}
  logic [28:0] exp_q [$];

  always @(negedge clk) begin
    if (rst_n && (bus_we || bus_rd)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected bus cycle", {bus_we, bus_addr, bus_wdata}, 0);
      end else begin
        logic [28:0] e;
        e = exp_q.pop_front();
        if (e[28]) begin
          chk(bus_we && bus_addr == e[27:16] && bus_wdata == e[15:0],
              (e[15:0] == 16'h00FF) ? "R11 array write" : "R2 command write",
              {bus_we, bus_addr, bus_wdata}, e);
        end else begin
          chk(bus_rd && bus_addr == e[27:16], "R3 read address",
              {bus_rd, bus_addr}, {1'b1, e[27:16]});
        end
      end
    end
  end

  function automatic longint p2(input int n);
    return (n < 32) ? (64'd1 << n) : 64'd0;
  endfunction

  task automatic set_tbl(input logic [7:0] q, r, y, e25, e27, e2a,
                         c1l, c1h, s1l, s1h, c2l, c2h, s2l, s2h);
    tbl[8'h10] = q;   tbl[8'h11] = r;   tbl[8'h12] = y;
    tbl[8'h25] = e25; tbl[8'h27] = e27; tbl[8'h2A] = e2a;
    tbl[8'h2D] = c1l; tbl[8'h2E] = c1h; tbl[8'h2F] = s1l; tbl[8'h30] = s1h;
    tbl[8'h31] = c2l; tbl[8'h32] = c2h; tbl[8'h33] = s2l; tbl[8'h34] = s2h;
  endtask

  task automatic run(input string name, input bit extra_start);
    logic [7:0] offs [14];
    bit good;
    int waited;
    offs = '{8'h10, 8'h11, 8'h12, 8'h25, 8'h27, 8'h2A, 8'h2D,
             8'h2E, 8'h2F, 8'h30, 8'h31, 8'h32, 8'h33, 8'h34};
    good = (tbl[8'h10] == 8'h51) && (tbl[8'h11] == 8'h52) && (tbl[8'h12] == 8'h59);
    exp_q.push_back({1'b1, BASE, 16'h0050});
    exp_q.push_back({1'b1, BASE, 16'h0098});
    for (int i = 0; i < (good ? 14 : 3); i++)
      exp_q.push_back({1'b0, BASE + 12'({offs[i], 1'b0}), 16'h0});
    exp_q.push_back({1'b1, BASE, 16'h00FF});

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done, {"R1 accepted busy/done ", name}, {busy, done}, 2'b10);
    if (extra_start) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk); waited++;
    end
    chk(done && !busy, {"R11 done reached ", name}, {done, busy}, 2'b10);
    chk(exp_q.size() == 0, {"R3 all bus cycles seen ", name}, exp_q.size(), 0);
    chk(sig_ok == good, {"R5 sig_ok ", name}, sig_ok, good);
    if (good) begin
      chk(dev_bytes == p2(tbl[8'h27]), {"R6 dev_bytes ", name}, dev_bytes, p2(tbl[8'h27]));
      chk(wbuf_words == (p2(tbl[8'h2A]) >> 1), {"R7 wbuf_words ", name},
          wbuf_words, p2(tbl[8'h2A]) >> 1);
      chk(erase_time == p2(tbl[8'h25]), {"R8 erase_time ", name}, erase_time, p2(tbl[8'h25]));
      chk(r1_blocks == {tbl[8'h2E], tbl[8'h2D]} + 17'd1, {"R9 r1_blocks R4 ", name},
          r1_blocks, {tbl[8'h2E], tbl[8'h2D]} + 17'd1);
      chk(r2_blocks == {tbl[8'h32], tbl[8'h31]} + 17'd1, {"R9 r2_blocks ", name},
          r2_blocks, {tbl[8'h32], tbl[8'h31]} + 17'd1);
      chk(r1_bytes == {tbl[8'h30], tbl[8'h2F], 8'h00}, {"R10 r1_bytes R4 ", name},
          r1_bytes, {tbl[8'h30], tbl[8'h2F], 8'h00});
      chk(r2_bytes == {tbl[8'h34], tbl[8'h33], 8'h00}, {"R10 r2_bytes ", name},
          r2_bytes, {tbl[8'h34], tbl[8'h33], 8'h00});
    end else begin
      chk({dev_bytes, wbuf_words, erase_time, r1_blocks, r1_bytes, r2_blocks, r2_bytes} == '0,
          {"R5 zero geometry ", name}, dev_bytes | wbuf_words | erase_time, 0);
    end
    repeat (8) @(negedge clk);
    chk(done && !busy && exp_q.size() == 0, {"R11 done holds, R1 no restart ", name},
        {done, busy}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sig_ok && !bus_we && !bus_rd, "R12 reset outputs",
        {busy, done, sig_ok, bus_we, bus_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({dev_bytes, wbuf_words, erase_time, r1_blocks, r1_bytes, r2_blocks, r2_bytes} == '0 &&
        !busy && !done, "R12 reset results", dev_bytes, 0);

    set_tbl(8'h51, 8'h52, 8'h59, 8'h0A, 8'h16, 8'h05,
            8'h3E, 8'h00, 8'h00, 8'h01, 8'h07, 8'h00, 8'h20, 8'h00);
    run("typical", 1'b1);

    set_tbl(8'h51, 8'h52, 8'h59, 8'h28, 8'h1F, 8'h00,
            8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h01, 8'h00);
    run("limits", 1'b0);

    set_tbl(8'h51, 8'h52, 8'h5A, 8'h0A, 8'h16, 8'h05,
            8'h3E, 8'h00, 8'h00, 8'h01, 8'h07, 8'h00, 8'h20, 8'h00);
    run("bad third char", 1'b0);

    set_tbl(8'h00, 8'h52, 8'h59, 8'h0A, 8'h16, 8'h05,
            8'h3E, 8'h00, 8'h00, 8'h01, 8'h07, 8'h00, 8'h20, 8'h00);
    run("bad first char", 1'b0);

    set_tbl(8'h51, 8'h52, 8'h59, 8'h01, 8'h20, 8'h01,
            8'h00, 8'h01, 8'h80, 8'h00, 8'hFE, 8'hFF, 8'hFF, 8'hFF);
    run("recover after bad", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule